// File: doc/BRIEF.md
# Guarded Trajectory Check Monitor

This monitor sits beside one atom of a running design and judges a single antecedent/consequent pair against it. An atom is a word carried with a one-bit invalid flag: when the flag is set, the whole word stands for "unknown" and its value bits mean nothing. The pair is loaded through a small configuration port. Each half of the pair is a tuple with a guard bit, an expected value, a first cycle and an end cycle.

While the antecedent tuple is active, the monitor joins the atom from the circuit with the atom the antecedent asserts, using a least-upper-bound join. It drives the result onto its atom output, and every downstream consumer reads that output. Two valid atoms with different values have no common upper bound; that case is a conflict and is recorded as an antecedent failure. While the consequent tuple is active with its guard set, the atom output must be valid and equal to the expected word; otherwise a consequent failure is recorded.

Both failure flags are sticky. A mode bit chooses how they combine into one verdict, and a done flag marks the end of both windows. Loading a configuration restarts the run.

Top module: `traj_monitor`

## Requirements
- R1: After reset, and in the cycle after a configuration load, the cycle counter is 0 and ant_fail, chk_fail and done are all 0. A load captures every cfg_* field.
- R2: In cycles outside the antecedent window, atom_val equals dut_val and atom_inv equals dut_inv.
- R3: Inside the antecedent window, the asserted atom has value cfg_ant_val and invalid flag equal to NOT guard. When there is no conflict, atom_inv is dut_inv AND the asserted flag. atom_val is the asserted value when dut_inv is 1, and dut_val otherwise.
- R4: A conflict occurs when the antecedent is active, the guard is 1, dut_inv is 0 and dut_val differs from cfg_ant_val. In that cycle atom_val is dut_val and atom_inv is 0, and ant_fail is 1 from the next cycle.
- R5: An antecedent whose guard is 0 never conflicts, and it leaves a valid circuit atom unchanged.
- R6: A tuple is active while the cycle counter lies in [start, end-1]. The counter is 0 in the first cycle after a load and then counts up by one each cycle.
- R7: While the consequent is active with guard 1, an atom output that is invalid or differs from cfg_chk_val sets chk_fail from the next cycle. A consequent whose guard is 0 checks nothing.
- R8: ant_fail and chk_fail stay set until the next reset or load.
- R9: done rises in the cycle after the one in which the counter equals the larger of the two end cycles, and it then stays 1.
- R10: With mode 1, verdict is ant_fail OR chk_fail. With mode 0, verdict is chk_fail AND NOT ant_fail, so an antecedent failure masks the consequent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture all cfg_* fields and restart the run |
| cfg_mode | input | 1 | Verdict mode (1 strict, 0 masked) |
| cfg_ant_guard | input | 1 | Antecedent guard |
| cfg_ant_val | input | W | Antecedent asserted value |
| cfg_ant_start | input | CW | Antecedent first active cycle |
| cfg_ant_end | input | CW | Antecedent end cycle (exclusive) |
| cfg_chk_guard | input | 1 | Consequent guard |
| cfg_chk_val | input | W | Consequent expected value |
| cfg_chk_start | input | CW | Consequent first active cycle |
| cfg_chk_end | input | CW | Consequent end cycle (exclusive) |
| dut_val | input | W | Atom value driven by the circuit |
| dut_inv | input | 1 | Atom invalid flag driven by the circuit |
| atom_val | output | W | Joined atom value |
| atom_inv | output | 1 | Joined atom invalid flag |
| ant_fail | output | 1 | Sticky antecedent failure |
| chk_fail | output | 1 | Sticky consequent failure |
| verdict | output | 1 | Overall failure per mode |
| done | output | 1 | Both windows finished |

## Verification
An antecedent conflict and a consequent check can fall in the same cycle, because the consequent judges the joined atom while the join is reporting a conflict. The bench provokes this by opening both windows at cycle 0 with a guarded antecedent and a guarded consequent whose values differ from each other and from a valid circuit word. It then expects both sticky flags one cycle later, and it expects the verdict to be masked in mode 0 and raised in mode 1 after an identical reload.

// File: rtl/traj_monitor.sv
module traj_monitor #(
  parameter int W  = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_mode,
  input  logic          cfg_ant_guard,
  input  logic [W-1:0]  cfg_ant_val,
  input  logic [CW-1:0] cfg_ant_start,
  input  logic [CW-1:0] cfg_ant_end,
  input  logic          cfg_chk_guard,
  input  logic [W-1:0]  cfg_chk_val,
  input  logic [CW-1:0] cfg_chk_start,
  input  logic [CW-1:0] cfg_chk_end,
  input  logic [W-1:0]  dut_val,
  input  logic          dut_inv,
  output logic [W-1:0]  atom_val,
  output logic          atom_inv,
  output logic          ant_fail,
  output logic          chk_fail,
  output logic          verdict,
  output logic          done
);

  logic          a_g, c_g, mode_q;
  logic [W-1:0]  a_v, c_v;
  logic [CW-1:0] a_s, a_e, c_s, c_e, cnt;
  logic          af_q, cf_q, done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_g <= 1'b0; a_v <= '0; a_s <= '0; a_e <= '0;
      c_g <= 1'b0; c_v <= '0; c_s <= '0; c_e <= '0;
      mode_q <= 1'b0;
    end else if (cfg_load) begin
      a_g <= cfg_ant_guard; a_v <= cfg_ant_val; a_s <= cfg_ant_start; a_e <= cfg_ant_end;
      c_g <= cfg_chk_guard; c_v <= cfg_chk_val; c_s <= cfg_chk_start; c_e <= cfg_chk_end;
      mode_q <= cfg_mode;
    end
  end

  wire           ant_act = (cnt >= a_s) && (cnt < a_e);
  wire           chk_act = (cnt >= c_s) && (cnt < c_e);
  wire           assert_on = ant_act && a_g;
  wire           clash = assert_on && !dut_inv && (dut_val != a_v);
  wire [CW-1:0]  last_end = (a_e > c_e) ? a_e : c_e;

  assign atom_inv = dut_inv && !assert_on;
  assign atom_val = (ant_act && dut_inv) ? a_v : dut_val;

  wire           chk_err = chk_act && c_g && (atom_inv || (atom_val != c_v));

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_load) begin
      cnt    <= '0;
      af_q   <= 1'b0;
      cf_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (!done_q && cnt != '1) cnt <= cnt + 1'b1;
      af_q   <= af_q || clash;
      cf_q   <= cf_q || chk_err;
      done_q <= done_q || (cnt >= last_end);
    end
  end

  assign ant_fail = af_q;
  assign chk_fail = cf_q;
  assign done     = done_q;
  assign verdict  = mode_q ? (af_q || cf_q) : (cf_q && !af_q);

  p_load_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!ant_fail && !chk_fail && !done));

  p_valid_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dut_inv |-> (!atom_inv && atom_val == dut_val));

  p_clash_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clash && !cfg_load) |=> ant_fail);

  p_chk_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_err && !cfg_load) |=> chk_fail);

  p_ant_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ant_fail && !cfg_load) |=> ant_fail);

  p_chk_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fail && !cfg_load) |=> chk_fail);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_load) |=> done);

endmodule

// File: tb/test_traj_monitor.sv
module test_traj_monitor;
  localparam int W = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_mode = 1'b0;
  logic cfg_ant_guard = 1'b0, cfg_chk_guard = 1'b0;
  logic [W-1:0] cfg_ant_val = '0, cfg_chk_val = '0;
  logic [CW-1:0] cfg_ant_start = '0, cfg_ant_end = '0, cfg_chk_start = '0, cfg_chk_end = '0;
  logic [W-1:0] dut_val = '0;
  logic dut_inv = 1'b0;
  logic [W-1:0] atom_val;
  logic atom_inv, ant_fail, chk_fail, verdict, done;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  traj_monitor #(.W(W), .CW(CW)) i_traj_monitor (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_ant_guard(cfg_ant_guard), .cfg_ant_val(cfg_ant_val),
    .cfg_ant_start(cfg_ant_start), .cfg_ant_end(cfg_ant_end),
    .cfg_chk_guard(cfg_chk_guard), .cfg_chk_val(cfg_chk_val),
    .cfg_chk_start(cfg_chk_start), .cfg_chk_end(cfg_chk_end),
    .dut_val(dut_val), .dut_inv(dut_inv), .atom_val(atom_val), .atom_inv(atom_inv),
    .ant_fail(ant_fail), .chk_fail(chk_fail), .verdict(verdict), .done(done));

  // dut_val, dut_inv, exp_val, exp_inv, exp_chk_fail, exp_done
  localparam logic [19:0] TBL [8] = '{
    {8'h11, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0},
    {8'h22, 1'b1, 8'h22, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0},
    {8'h33, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0},
    {8'h44, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic load(input logic md,
                      input logic ag, input logic [W-1:0] av, input logic [CW-1:0] as_, input logic [CW-1:0] ae,
                      input logic cg, input logic [W-1:0] cv, input logic [CW-1:0] cs, input logic [CW-1:0] ce);
    @(negedge clk);
    cfg_mode = md;
    cfg_ant_guard = ag; cfg_ant_val = av; cfg_ant_start = as_; cfg_ant_end = ae;
    cfg_chk_guard = cg; cfg_chk_val = cv; cfg_chk_start = cs; cfg_chk_end = ce;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic drive(input logic [W-1:0] v, input logic inv);
    dut_val = v; dut_inv = inv;
    #2;
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    drive(8'h3C, 1'b0);
    check("R1 reset ant_fail", ant_fail, 0);
    check("R1 reset chk_fail", chk_fail, 0);
    check("R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(8'h3C, 1'b1);
    check("R2 idle pass val", atom_val, 8'h3C);
    check("R2 idle pass inv", atom_inv, 1);

    // table walk: R2 R3 R6 R7 R9
    load(1'b1, 1'b1, 8'h5A, 8'd2, 8'd5, 1'b1, 8'h5A, 8'd3, 8'd6);
    for (int i = 0; i < 8; i++) begin
      drive(TBL[i][19:12], TBL[i][11]);
      check($sformatf("R3 R6 cycle %0d val", i), atom_val, TBL[i][10:3]);
      check($sformatf("R2 R3 cycle %0d inv", i), atom_inv, TBL[i][2]);
      check($sformatf("R7 cycle %0d chk_fail", i), chk_fail, TBL[i][1]);
      check($sformatf("R9 cycle %0d done", i), done, TBL[i][0]);
      check($sformatf("R4 cycle %0d ant_fail", i), ant_fail, 0);
      @(negedge clk);
    end
    drive(8'h00, 1'b0);
    check("R10 strict verdict on chk_fail", verdict, 1);

    // conflict in antecedent, consequent unguarded, mode 0
    load(1'b0, 1'b1, 8'hAA, 8'd0, 8'd2, 1'b0, 8'h00, 8'd0, 8'd1);
    drive(8'h55, 1'b0);
    check("R1 flags clear after load", ant_fail | chk_fail | done, 0);
    check("R4 conflict val keeps circuit", atom_val, 8'h55);
    check("R4 conflict inv", atom_inv, 0);
    @(negedge clk);
    drive(8'h00, 1'b1);
    check("R4 ant_fail raised", ant_fail, 1);
    check("R3 invalid joined val", atom_val, 8'hAA);
    check("R3 invalid joined inv", atom_inv, 0);
    check("R10 mode0 no chk fail verdict", verdict, 0);
    @(negedge clk);
    drive(8'h00, 1'b1);
    check("R8 ant_fail sticky", ant_fail, 1);
    check("R2 after window inv", atom_inv, 1);
    check("R9 done not yet", done, 0);
    @(negedge clk);
    drive(8'h00, 1'b0);
    check("R9 done after last end", done, 1);
    check("R8 ant_fail still sticky", ant_fail, 1);

    // guard false everywhere
    load(1'b1, 1'b0, 8'hAA, 8'd0, 8'd3, 1'b0, 8'h77, 8'd0, 8'd3);
    drive(8'h55, 1'b0);
    check("R5 guard0 keeps val", atom_val, 8'h55);
    check("R5 guard0 keeps valid", atom_inv, 0);
    @(negedge clk);
    drive(8'h12, 1'b1);
    check("R5 guard0 leaves invalid", atom_inv, 1);
    check("R5 no conflict flag", ant_fail, 0);
    @(negedge clk);
    drive(8'h12, 1'b1);
    @(negedge clk);
    drive(8'h12, 1'b0);
    check("R7 guard0 consequent no check", chk_fail, 0);
    check("R5 ant_fail stays 0", ant_fail, 0);

    // consequent sees invalid atom
    load(1'b0, 1'b0, 8'h00, 8'd0, 8'd0, 1'b1, 8'h07, 8'd1, 8'd2);
    drive(8'h07, 1'b1);
    @(negedge clk);
    drive(8'h07, 1'b1);
    check("R6 consequent not active at cycle 0", chk_fail, 0);
    @(negedge clk);
    drive(8'h07, 1'b0);
    check("R7 invalid atom fails consequent", chk_fail, 1);
    check("R10 mode0 verdict unmasked", verdict, 1);

    // both functions in one cycle, mode 0 then mode 1
    load(1'b0, 1'b1, 8'h01, 8'd0, 8'd1, 1'b1, 8'h02, 8'd0, 8'd1);
    drive(8'h03, 1'b0);
    @(negedge clk);
    drive(8'h03, 1'b0);
    check("R4 same-cycle ant_fail", ant_fail, 1);
    check("R7 same-cycle chk_fail", chk_fail, 1);
    check("R10 mode0 masked verdict", verdict, 0);
    load(1'b1, 1'b1, 8'h01, 8'd0, 8'd1, 1'b1, 8'h02, 8'd0, 8'd1);
    drive(8'h03, 1'b0);
    check("R1 reload clears verdict", verdict, 0);
    @(negedge clk);
    drive(8'h03, 1'b0);
    check("R10 mode1 verdict", verdict, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule